// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block turns single-byte processor requests into strobe sequences for an asynchronous DRAM whose row and column addresses share one set of address pins. A 21-bit byte address is split into a row part and a column part. The row goes out first with the row strobe, and the column follows with the column strobe. When the access finishes, the controller raises a one-cycle done pulse and, for reads, returns the byte.

After an access the row stays open. A later request to the same row then needs only a new column strobe. A request to a different row first precharges, with the row strobe released, and then runs the full row-then-column sequence. An internal interval timer requests refresh cycles. Each refresh is a row-strobe-only cycle on the row named by a wrapping refresh row counter. A pending refresh takes priority over processor requests and closes any open row before it starts.

Request side rules: the requester holds `req_valid`, `req_addr`, `req_we` and `req_wdata` stable until a cycle in which `req_ready` is high. `req_ready` is high only when the controller is idle with no refresh pending, so at most one request is outstanding. The response is a single-cycle `rsp_valid` pulse with no back-pressure, and the consumer must take it in that cycle.

Top module: `dram_page_ctrl`

## Requirements
- R1: The row is `req_addr[20:9]` and is on `dram_addr` when `dram_ras_n` falls. The column is `req_addr[8:0]` and is on `dram_addr[8:0]` when `dram_cas_n` falls. The row stays stable on the bus while the row strobe is low and the column strobe is high.
- R2: `dram_cas_n` is low only while `dram_ras_n` is low. After a row strobe falls, at least RCD_CYC cycles pass before the first column strobe. `dram_cs_n` is low whenever either strobe is low.
- R3: A request to the row that is already open produces a column strobe only, with no new row strobe.
- R4: Before each falling row strobe, `dram_ras_n` has been high for at least PRE_CYC cycles. This includes the case where a request to a different row closes the open row.
- R5: A read returns the byte last written to that address through the controller.
- R6: Every accepted request yields exactly one `rsp_valid` pulse, one cycle long. `req_ready` stays low from acceptance until the pulse.
- R7: A refresh is a cycle in which `dram_ras_n` is low for exactly REF_CYC cycles with `dram_cas_n` high. The row address starts at 0 after reset and increments by one per refresh, modulo 4096.
- R8: One refresh is requested every REF_INTERVAL cycles. While a refresh is pending, no request is accepted. The open row is precharged before the refresh, so refreshes stay evenly spaced under continuous traffic.
- R9: After a refresh, the next access reopens its row with a new row strobe, even if that row was open before.
- R10: During reset, all strobes, `dram_cs_n` and `dram_we_n` are high, `dram_dq_oe` and `rsp_valid` are low. After reset, `req_ready` is high.
- R11: A write holds `dram_we_n` low and `dram_dq_oe` high together with the column strobe and drives `req_wdata` on `dram_dq_out`. `dram_dq_oe` is never high outside a write column strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 21 | Byte address, row in [20:9], column in [8:0] |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid on reads |
| dram_addr | output | 12 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_dq_out | output | 8 | Write data to memory |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | 8 | Read data from memory |

## Verification
The bench builds the controller with REF_INTERVAL = 400, so a few thousand cycles of traffic contain about nine refreshes, and each refresh's spacing and row number can be checked against the interval. RCD_CYC = 2 and CAS_CYC = 2 make the row-to-column spacing and the read capture point distinct from a single cycle. PRE_CYC = 1 puts the precharge check at its tightest legal case. A behavioural DRAM in the bench counts row openings, so page hits, page misses and the reopening after a refresh show up as exact counts.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL,
    ST_DONE,
    ST_REF
  } dpc_state_t;

  typedef enum logic [1:0] {
    AP_IDLE,
    AP_ROW,
    AP_REF
  } dpc_after_t;
endpackage

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int REF_INTERVAL = 1953,
  parameter int ROW_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = $clog2(REF_INTERVAL + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt        <= '0;
      ref_pending <= 1'b0;
      ref_row     <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + TW'(1);
      if (ref_done) begin
        ref_pending <= 1'b0;
        ref_row     <= ref_row + ROW_W'(1);
      end
      if (tick) ref_pending <= 1'b1;
    end
  end
endmodule

// File: rtl/dpc_page_tracker.sv
module dpc_page_tracker #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] query_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (open_clr) begin
      is_open <= 1'b0;
    end else if (open_set) begin
      is_open  <= 1'b1;
      open_row <= set_row;
    end
  end

  assign hit = is_open && (open_row == query_row);
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int PRE_CYC = 1,
  parameter int RCD_CYC = 2,
  parameter int CAS_CYC = 2,
  parameter int REF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pending,
  input  logic       req_valid,
  input  logic       row_hit,
  input  logic       row_open,
  output dpc_state_t state,
  output logic       step_last,
  output logic       req_ready
);
  localparam int M1   = (PRE_CYC > RCD_CYC) ? PRE_CYC : RCD_CYC;
  localparam int M2   = (CAS_CYC > REF_CYC) ? CAS_CYC : REF_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  dpc_state_t    nxt;
  dpc_after_t    after_pre, after_pre_nxt;

  always_comb begin
    case (state)
      ST_PRE:  lim = CW'(PRE_CYC);
      ST_ROW:  lim = CW'(RCD_CYC);
      ST_COL:  lim = CW'(CAS_CYC);
      ST_REF:  lim = CW'(REF_CYC);
      default: lim = CW'(1);
    endcase
  end

  assign step_last = (cnt == lim - CW'(1));
  assign req_ready = (state == ST_IDLE) && !ref_pending;

  always_comb begin
    nxt           = state;
    after_pre_nxt = after_pre;
    case (state)
      ST_IDLE: begin
        if (ref_pending) begin
          if (row_open) begin
            nxt           = ST_PRE;
            after_pre_nxt = AP_REF;
          end else begin
            nxt = ST_REF;
          end
        end else if (req_valid) begin
          if (row_hit) begin
            nxt = ST_COL;
          end else if (row_open) begin
            nxt           = ST_PRE;
            after_pre_nxt = AP_ROW;
          end else begin
            nxt = ST_ROW;
          end
        end
      end
      ST_PRE: begin
        if (step_last) begin
          case (after_pre)
            AP_ROW:  nxt = ST_ROW;
            AP_REF:  nxt = ST_REF;
            default: nxt = ST_IDLE;
          endcase
        end
      end
      ST_ROW:  if (step_last) nxt = ST_COL;
      ST_COL:  if (step_last) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      ST_REF: begin
        if (step_last) begin
          nxt           = ST_PRE;
          after_pre_nxt = AP_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_pre <= AP_IDLE;
      cnt       <= '0;
    end else begin
      state     <= nxt;
      after_pre <= after_pre_nxt;
      cnt       <= (nxt != state) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int PRE_CYC      = 1,
  parameter int RCD_CYC      = 2,
  parameter int CAS_CYC      = 2,
  parameter int REF_CYC      = 4,
  parameter int REF_INTERVAL = 1953,
  localparam int ROW_W       = ADDR_W - COL_W,
  localparam int BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_cs_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  dpc_state_t        st;
  logic              step_last;
  logic              ref_pending;
  logic [ROW_W-1:0]  ref_row;
  logic              row_open, row_hit;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_we;
  logic [DATA_W-1:0] cur_wdata;
  logic              accept;
  logic              ras_on, cas_on;

  assign accept = req_valid && req_ready;

  dpc_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .ROW_W       (ROW_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_done   ((st == ST_REF) && step_last),
    .ref_pending(ref_pending),
    .ref_row    (ref_row)
  );

  dpc_page_tracker #(
    .ROW_W(ROW_W)
  ) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_set (st == ST_ROW),
    .open_clr ((st == ST_PRE) || (st == ST_REF)),
    .set_row  (cur_row),
    .query_row(req_addr[ADDR_W-1:COL_W]),
    .is_open  (row_open),
    .hit      (row_hit)
  );

  dpc_seq #(
    .PRE_CYC(PRE_CYC),
    .RCD_CYC(RCD_CYC),
    .CAS_CYC(CAS_CYC),
    .REF_CYC(REF_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_pending(ref_pending),
    .req_valid  (req_valid),
    .row_hit    (row_hit),
    .row_open   (row_open),
    .state      (st),
    .step_last  (step_last),
    .req_ready  (req_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_row   <= '0;
      cur_col   <= '0;
      cur_we    <= 1'b0;
      cur_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        cur_row   <= req_addr[ADDR_W-1:COL_W];
        cur_col   <= req_addr[COL_W-1:0];
        cur_we    <= req_we;
        cur_wdata <= req_wdata;
      end
      if ((st == ST_COL) && step_last && !cur_we) rsp_rdata <= dram_dq_in;
    end
  end

  always_comb begin
    case (st)
      ST_ROW, ST_COL, ST_DONE, ST_REF: ras_on = 1'b1;
      ST_IDLE:                         ras_on = row_open;
      default:                         ras_on = 1'b0;
    endcase
  end

  assign cas_on      = (st == ST_COL);
  assign dram_ras_n  = !ras_on;
  assign dram_cas_n  = !cas_on;
  assign dram_cs_n   = !(ras_on || cas_on);
  assign dram_we_n   = !(cas_on && cur_we);
  assign dram_dq_oe  = cas_on && cur_we;
  assign dram_dq_out = cur_wdata;
  assign rsp_valid   = (st == ST_DONE);

  always_comb begin
    case (st)
      ST_COL:  dram_addr = BUS_W'(cur_col);
      ST_REF:  dram_addr = BUS_W'(ref_row);
      default: dram_addr = BUS_W'(cur_row);
    endcase
  end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int BUS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             ref_pending,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe,
  input logic [BUS_W-1:0] dram_addr
);
  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_cas_inside_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_row_bus_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $past(!dram_ras_n) && dram_cas_n && $past(dram_cas_n))
      |-> $stable(dram_addr));

  assert_drive_only_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_cas_n && !dram_we_n));

  assert_refresh_blocks_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !(req_valid && req_ready));
endmodule

bind dram_page_ctrl dpc_checker #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ref_pending(ref_pending),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_dq_oe (dram_dq_oe),
  .dram_addr  (dram_addr)
);

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;
  localparam int PRE  = 1;
  localparam int RCD  = 2;
  localparam int CASC = 2;
  localparam int REFC = 4;
  localparam int INTV = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_cs_n, dram_dq_oe;
  logic [7:0]  dram_dq_out;
  logic [7:0]  model_dq = '0;

  always #4 clk = !clk;

  dram_page_ctrl #(
    .PRE_CYC(PRE), .RCD_CYC(RCD), .CAS_CYC(CASC), .REF_CYC(REFC), .REF_INTERVAL(INTV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_cs_n(dram_cs_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(model_dq)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]};
  endfunction

  // behavioural DRAM and bus reference
  logic [7:0]  mem [int];
  logic [7:0]  ref_mem [int];
  logic [11:0] m_row = '0;
  bit          prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;
  int          hi_cnt = 8, low_cnt = 0, hi_at_fall = 8;
  int          act_cnt = 0, ref_cnt = 0, exp_ref = 0, last_ref = -1;
  bit          busy = 1'b0;
  logic [20:0] cur_addr = '0;
  logic [7:0]  cur_wdata = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; hi_cnt = 8; low_cnt = 0;
    end else begin
      if (!dram_ras_n && prev_ras) begin
        hi_at_fall = hi_cnt;
        chk(hi_cnt >= PRE, "R4 precharge before row strobe", hi_cnt, PRE);
        m_row = dram_addr; saw_cas = 1'b0; low_cnt = 1;
      end else if (!dram_ras_n) begin
        low_cnt++;
      end
      if (dram_ras_n && !prev_ras) begin
        if (!saw_cas) begin
          chk(low_cnt == REFC, "R7 refresh strobe length", low_cnt, REFC);
          chk(int'(m_row) == exp_ref, "R7 refresh row", int'(m_row), exp_ref);
          chk(hi_at_fall >= PRE, "R8 row closed before refresh", hi_at_fall, PRE);
          if (last_ref >= 0)
            chk((cyc - last_ref >= INTV - 12) && (cyc - last_ref <= INTV + 12),
                "R8 refresh spacing", cyc - last_ref, INTV);
          last_ref = cyc;
          exp_ref  = (exp_ref + 1) % 4096;
          ref_cnt++;
        end
        hi_cnt = 1;
      end else if (dram_ras_n) begin
        hi_cnt++;
      end
      if (!dram_cas_n && prev_cas) begin
        int key;
        chk(!dram_ras_n && !dram_cs_n, "R2 column strobe inside row strobe", int'(dram_ras_n), 0);
        if (!saw_cas) begin
          chk(low_cnt - 1 >= RCD, "R2 row-to-column delay", low_cnt - 1, RCD);
          act_cnt++;
        end
        saw_cas = 1'b1;
        key = int'({m_row, dram_addr[8:0]});
        if (busy) chk({m_row, dram_addr[8:0]} == cur_addr, "R1 address split", key, int'(cur_addr));
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_dq_out == cur_wdata, "R11 write data driven",
              int'(dram_dq_out), int'(cur_wdata));
          mem[key] = dram_dq_out;
        end else begin
          model_dq = mem.exists(key) ? mem[key] : dflt(key);
        end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      if (rsp_valid && !busy) chk(1'b0, "R6 done without request", 1, 0);
    end
  end

  task automatic access(input bit we, input logic [20:0] a, input logic [7:0] d);
    int guard = 0;
    busy = 1'b1; cur_addr = a; cur_wdata = d;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 ready low after accept", int'(req_ready), 0);
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(rsp_valid, "R6 done pulse seen", int'(rsp_valid), 1);
    if (!we) begin
      logic [7:0] e;
      e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(int'(a));
      chk(rsp_rdata == e, "R5 read data", int'(rsp_rdata), int'(e));
    end else begin
      ref_mem[int'(a)] = d;
    end
    @(negedge clk);
    chk(!rsp_valid, "R6 done lasts one cycle", int'(rsp_valid), 0);
    busy = 1'b0;
  endtask

  task automatic wait_refresh();
    int r0 = ref_cnt;
    int guard = 0;
    while (ref_cnt == r0 && guard < 2000) begin @(negedge clk); guard++; end
    chk(ref_cnt != r0, "R8 refresh occurs", ref_cnt - r0, 1);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a0, r0, c0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_cs_n && dram_we_n && !dram_dq_oe && !rsp_valid,
        "R10 reset outputs", {dram_ras_n, dram_cas_n, dram_cs_n, dram_we_n, dram_dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", int'(req_ready), 1);

    // page hits and misses just after a refresh
    wait_refresh();
    a0 = act_cnt;
    access(1'b1, {12'h091, 9'h045}, 8'hA5);
    access(1'b1, {12'h091, 9'h1F0}, 8'h3C);
    access(1'b0, {12'h091, 9'h045}, 8'h00);
    access(1'b0, {12'h091, 9'h1F0}, 8'h00);
    chk(act_cnt - a0 == 1, "R3 same-row accesses open row once", act_cnt - a0, 1);
    access(1'b1, {12'hFFF, 9'h000}, 8'h81);
    chk(act_cnt - a0 == 2, "R4 row miss reopens", act_cnt - a0, 2);
    access(1'b0, {12'h091, 9'h045}, 8'h00);
    chk(act_cnt - a0 == 3, "R4 return to first row reopens", act_cnt - a0, 3);
    access(1'b0, {12'h000, 9'h1FF}, 8'h00);
    access(1'b0, {12'hFFF, 9'h000}, 8'h00);

    // refresh closes the open row
    access(1'b0, {12'h123, 9'h011}, 8'h00);
    wait_refresh();
    a0 = act_cnt;
    access(1'b0, {12'h123, 9'h011}, 8'h00);
    chk(act_cnt - a0 == 1, "R9 row reopened after refresh", act_cnt - a0, 1);

    // continuous traffic with interleaved refreshes
    access(1'b0, {12'h777, 9'h000}, 8'h00);
    a0 = act_cnt; r0 = ref_cnt; c0 = cyc;
    for (int i = 0; i < 300; i++) begin
      access(1'b1, {12'h005, 9'(i)}, 8'(i * 7 + 1));
      access(1'b0, {12'h005, 9'(i)}, 8'h00);
    end
    chk((ref_cnt - r0 >= (cyc - c0) / INTV - 1) && (ref_cnt - r0 <= (cyc - c0) / INTV + 1),
        "R8 refresh count under traffic", ref_cnt - r0, (cyc - c0) / INTV);
    chk((act_cnt - a0 == ref_cnt - r0 + 1) || (act_cnt - a0 == ref_cnt - r0),
        "R9 one reopen per refresh", act_cnt - a0, ref_cnt - r0 + 1);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule